// File: doc/BRIEF.md
# Receive Buffer with Count Acknowledge

This block holds the bytes a fast serial receiver has deserialized until host software collects them. Bytes arrive one per cycle on a valid/data input and are kept in arrival order in a 1024-byte store. The host never pops bytes one at a time. It reads as many as it wants through a memory-mapped window in which window byte k is always the k-th oldest unacknowledged byte. It then writes the number it has consumed to an acknowledge register, which frees that many bytes at once and moves the window forward.

A 32-bit register port gives access to the window, to a status word that reports the fill level, and to the configuration fields. Two request outputs notify the host. One rises once the fill level reaches a programmable threshold. The other rises when data has sat in the buffer with no new byte and no acknowledge for a programmable idle time.

Top module: `rx_ack_fifo`

## Requirements
- R1: After reset the buffer is empty. A read of the status word (address 0x000) returns 0, and both request outputs are low.
- R2: Received bytes are kept in arrival order. Window byte k sits at address 0x004+k. A 32-bit read of word address 0x004+4i returns window bytes 4i..4i+3, with byte 4i+j in bits [8j+7:8j]. Read data appears on `reg_rdata` in the cycle after `reg_rd`, and it holds when no read is issued.
- R3: The status word carries the fill count with count bits [7:0] in status bits [31:24] and count bits [9:8] in status bits [7:6]. Status bit 3 is 1 when all 1024 bytes are occupied. Status bit 1 mirrors `irq_data` and bit 2 mirrors `irq_tmo`.
- R4: Writing N in bits [10:0] to address 0x800 releases the N oldest bytes. The fill count drops by N, and window byte 0 becomes the byte that was at index N.
- R5: An acknowledge value larger than the fill count is clamped, so the buffer becomes empty and the count does not wrap.
- R6: A byte presented while all 1024 bytes are occupied is dropped and the stored data is unchanged. It sets the overrun flag in status bit 0, which stays set until a write to address 0x000 with bit 0 = 1.
- R7: `irq_data` is high while the fill count is at least 4 << L. L is the 3-bit level in bits [22:20] of address 0x804 and resets to 6 (256 bytes).
- R8: `irq_tmo` rises when the buffer is non-empty and T × D × 4 cycles have passed since the last accepted byte or acknowledge write. T is bits [15:0] of 0x808 and D is bits [15:0] of 0x80C. It falls on the next accepted byte, on an acknowledge write, or when the buffer empties. T = 0 or D = 0 disables it.
- R9: Window bytes at index equal to or beyond the fill count read as 0x00.
- R10: A byte arriving in the same cycle as an acknowledge write is stored. The new count is the old count minus the clamped acknowledge plus one. A byte arriving while the buffer is full is still dropped in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | Incoming byte is valid this cycle |
| rx_byte | input | 8 | Incoming byte from the deserializer |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |
| irq_data | output | 1 | Fill level has reached the trigger threshold |
| irq_tmo | output | 1 | Idle timeout with data still waiting |

## Verification
A wrong read or write pointer shows up in the window as soon as the next word is read. Bytes then come out shifted, repeated or stale relative to the scoreboard's arrival-ordered copy, and a bad clamp or wrap shows in the status count on the very next status read. A miscounted fill level moves the `irq_data` edge off the exact byte that crosses the threshold, and a wrong timer reload moves the `irq_tmo` edge outside a window of a few cycles around T × D × 4. Overrun mistakes show in two places: as a corrupted oldest byte once the buffer is full, and as a status bit that either fails to set or fails to hold until it is cleared.

// File: rtl/rx_ack_fifo_pkg.sv
package rx_ack_fifo_pkg;
  localparam int unsigned REG_AW = 12;
  localparam int unsigned REG_DW = 32;
  localparam int unsigned LVL_W  = 3;
  localparam int unsigned TMR_W  = 16;

  localparam logic [REG_AW-1:0] A_STATUS = 12'h000;
  localparam logic [REG_AW-1:0] A_WIN_LO = 12'h004;
  localparam logic [REG_AW-1:0] A_WIN_HI = 12'h3FF;
  localparam logic [REG_AW-1:0] A_ACK    = 12'h800;
  localparam logic [REG_AW-1:0] A_LEVEL  = 12'h804;
  localparam logic [REG_AW-1:0] A_IDLE   = 12'h808;
  localparam logic [REG_AW-1:0] A_DIV    = 12'h80C;

  localparam logic [LVL_W-1:0] LVL_RESET = 3'd6;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic [TMR_W-1:0] idle;
    logic [TMR_W-1:0] div;
  } cfg_t;
endpackage

// File: rtl/rx_ack_fifo_store.sv
module rx_ack_fifo_store #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned LANES = 4,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [7:0]         in_byte,
  input  logic               ack_wr,
  input  logic [CW-1:0]      ack_n,
  input  logic               ovr_clr,
  input  logic [CW-1:0]      win_off,
  output logic [8*LANES-1:0] win_word,
  output logic [CW-1:0]      count,
  output logic               full,
  output logic               overrun,
  output logic               push_ok
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] ack_amt;
  logic          ovr_q, ovr_d;
  logic          full_c, push;

  always_comb begin
    full_c   = (cnt_q == CW'(DEPTH));
    push     = in_valid && !full_c;
    ack_amt  = '0;
    if (ack_wr) ack_amt = (ack_n > cnt_q) ? cnt_q : ack_n;
    cnt_d    = cnt_q - ack_amt + CW'(push);
    wr_ptr_d = push ? wr_ptr_q + AW'(1) : wr_ptr_q;
    rd_ptr_d = rd_ptr_q + ack_amt[AW-1:0];
    ovr_d    = ovr_q;
    if (ovr_clr) ovr_d = 1'b0;
    if (in_valid && full_c) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovr_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      ovr_q    <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= in_byte;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [CW-1:0] k;
    logic [AW-1:0] phys;
    assign k    = win_off + CW'(j);
    assign phys = rd_ptr_q + k[AW-1:0];
    assign win_word[8*j +: 8] = (k < cnt_q) ? mem[phys] : 8'h00;
  end

  assign count   = cnt_q;
  assign full    = full_c;
  assign overrun = ovr_q;
  assign push_ok = push;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R6
  AST_PTR_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr_q - rd_ptr_q) == cnt_q[AW-1:0]); // R2
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full_c && !ack_wr) |=> (cnt_q == CW'(DEPTH))); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !ovr_clr) |=> ovr_q); // R6
  AST_ACK_NOGROW: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !in_valid) |=> (cnt_q <= $past(cnt_q))); // R5
endmodule

// File: rtl/rx_ack_fifo_timer.sv
module rx_ack_fifo_timer #(
  parameter int unsigned TW = 16,
  localparam int unsigned PW = TW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          nonempty,
  input  logic [TW-1:0] idle_lim,
  input  logic [TW-1:0] div,
  output logic          fire
);
  logic [PW-1:0] pre_q, pre_d, period;
  logic [TW-1:0] tk_q, tk_d;
  logic          fire_q, fire_d;

  always_comb begin
    period = {div, 2'b00};
    pre_d  = pre_q;
    tk_d   = tk_q;
    fire_d = fire_q;
    if (restart || !nonempty || idle_lim == '0 || div == '0) begin
      pre_d  = '0;
      tk_d   = '0;
      fire_d = 1'b0;
    end else if (!fire_q) begin
      if (pre_q == period - PW'(1)) begin
        pre_d = '0;
        if (tk_q == idle_lim - TW'(1)) fire_d = 1'b1;
        else                           tk_d   = tk_q + TW'(1);
      end else begin
        pre_d = pre_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tk_q   <= '0;
      fire_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      tk_q   <= tk_d;
      fire_q <= fire_d;
    end
  end

  assign fire = fire_q;

  AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> nonempty); // R8
  AST_TMO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !fire_q); // R8
endmodule

// File: rtl/rx_ack_fifo_csr.sv
module rx_ack_fifo_csr
  import rx_ack_fifo_pkg::*;
#(
  parameter int unsigned CW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic [CW-1:0]     count,
  input  logic              full,
  input  logic              overrun,
  input  logic              tmo_req,
  input  logic [31:0]       win_word,
  output logic [CW-1:0]     win_off,
  output logic              ack_wr,
  output logic [CW-1:0]     ack_n,
  output logic              ovr_clr,
  output logic              dav_req,
  output cfg_t              cfg
);
  cfg_t              cfg_q, cfg_d;
  logic [REG_DW-1:0] rdata_q, rdata_d;
  logic              win_hit;
  logic [CW-1:0]     thr;

  always_comb begin
    win_hit = (reg_addr >= A_WIN_LO) && (reg_addr <= A_WIN_HI);
    win_off = CW'({reg_addr[9:2] - 8'd1, 2'b00});
    ack_wr  = reg_wr && (reg_addr == A_ACK);
    ack_n   = reg_wdata[CW-1:0];
    ovr_clr = reg_wr && (reg_addr == A_STATUS) && reg_wdata[0];
    thr     = CW'(4) << cfg_q.lvl;
    dav_req = (count >= thr);
  end

  always_comb begin
    cfg_d = cfg_q;
    if (reg_wr) begin
      case (reg_addr)
        A_LEVEL: cfg_d.lvl  = reg_wdata[22:20];
        A_IDLE:  cfg_d.idle = reg_wdata[TMR_W-1:0];
        A_DIV:   cfg_d.div  = reg_wdata[TMR_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (reg_rd) begin
      rdata_d = '0;
      if (win_hit) begin
        rdata_d = win_word;
      end else begin
        case (reg_addr)
          A_STATUS: rdata_d = {count[7:0], 16'h0000, count[9:8], 2'b00,
                               full, tmo_req, dav_req, overrun};
          A_LEVEL:  rdata_d[22:20] = cfg_q.lvl;
          A_IDLE:   rdata_d[TMR_W-1:0] = cfg_q.idle;
          A_DIV:    rdata_d[TMR_W-1:0] = cfg_q.div;
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.lvl  <= LVL_RESET;
      cfg_q.idle <= '0;
      cfg_q.div  <= '0;
      rdata_q    <= '0;
    end else begin
      cfg_q      <= cfg_d;
      rdata_q    <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;
  assign cfg       = cfg_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata)); // R2
  AST_DAV_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !dav_req); // R7
endmodule

// File: rtl/rx_ack_fifo.sv
module rx_ack_fifo
  import rx_ack_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic [11:0] reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  input  logic        reg_rd,
  output logic [31:0] reg_rdata,
  output logic        irq_data,
  output logic        irq_tmo
);
  logic [1:0]    rst_sync_q;
  logic          rst_core_n;
  logic [CW-1:0] count, win_off, ack_n;
  logic [31:0]   win_word;
  logic          full, overrun, push_ok, ack_wr, ovr_clr, dav_req, tmo_req;
  cfg_t          cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  rx_ack_fifo_store #(.DEPTH(DEPTH), .LANES(4)) u_store (
    .clk(clk), .rst_n(rst_core_n),
    .in_valid(rx_valid), .in_byte(rx_byte),
    .ack_wr(ack_wr), .ack_n(ack_n), .ovr_clr(ovr_clr),
    .win_off(win_off), .win_word(win_word),
    .count(count), .full(full), .overrun(overrun), .push_ok(push_ok)
  );

  rx_ack_fifo_timer #(.TW(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_core_n),
    .restart(push_ok || ack_wr), .nonempty(count != '0),
    .idle_lim(cfg.idle), .div(cfg.div), .fire(tmo_req)
  );

  rx_ack_fifo_csr #(.CW(CW)) u_csr (
    .clk(clk), .rst_n(rst_core_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .count(count), .full(full), .overrun(overrun), .tmo_req(tmo_req),
    .win_word(win_word), .win_off(win_off),
    .ack_wr(ack_wr), .ack_n(ack_n), .ovr_clr(ovr_clr),
    .dav_req(dav_req), .cfg(cfg)
  );

  assign irq_data = dav_req;
  assign irq_tmo  = tmo_req;
endmodule

// File: tb/rx_ack_fifo_tb_top.sv
`timescale 1ns/1ps
module rx_ack_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic [11:0] reg_addr = 12'h000;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = 32'h0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        irq_data, irq_tmo;

  int checks = 0;
  int fails  = 0;

  logic [7:0]  model_q[$];
  bit          ovr_m = 1'b0;
  int          lvl_m = 6;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_d = 1'b0;

  always #4 clk = ~clk;

  rx_ack_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .irq_data(irq_data), .irq_tmo(irq_tmo)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] status_exp();
    int c = model_q.size();
    logic [10:0] cv = 11'(c);
    bit dav = (c >= (4 << lvl_m));
    return {cv[7:0], 16'h0, cv[9:8], 2'b00, (c == 1024), 1'b0, dav, ovr_m};
  endfunction

  function automatic logic [31:0] win_exp(int w);
    logic [31:0] r = '0;
    for (int j = 0; j < 4; j++) begin
      int k = 4 * (w - 1) + j;
      if (k < model_q.size()) r[8*j +: 8] = model_q[k];
    end
    return r;
  endfunction

  // scoreboard monitor: one expected item per issued read
  always @(posedge clk) rd_d <= reg_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected read data actual=%h expected=none", reg_rdata);
      end else begin
        check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    if (model_q.size() < 1024) model_q.push_back(b);
    else ovr_m = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic ack(int n);
    int m = (n > model_q.size()) ? model_q.size() : n;
    wr(12'h800, 32'(n));
    repeat (m) void'(model_q.pop_front());
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(12'h000, 32'h0, "R1 status after reset");
    check("R1 irq_data after reset", 32'(irq_data), 32'h0);
    check("R1 irq_tmo after reset", 32'(irq_tmo), 32'h0);
    rd(12'h804, 32'h0060_0000, "R7 default level 6");

    // R2/R3/R9 ten bytes in order
    for (int i = 0; i < 10; i++) push(8'h10 + 8'(i));
    rd(12'h000, status_exp(), "R3 status count 10");
    rd(12'h004, win_exp(1), "R2 window word 1");
    rd(12'h008, win_exp(2), "R2 window word 2");
    rd(12'h00C, win_exp(3), "R9 window tail beyond count");

    // R4 acknowledge of 3
    ack(3);
    rd(12'h004, win_exp(1), "R4 window after ack 3");
    rd(12'h008, win_exp(2), "R4 window word 2 after ack");
    rd(12'h000, status_exp(), "R4 status count 7");

    // R10 byte together with ack
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = 8'hEE; reg_wr = 1'b1; reg_addr = 12'h800; reg_wdata = 32'd2;
    repeat (2) void'(model_q.pop_front());
    model_q.push_back(8'hEE);
    @(negedge clk);
    rx_valid = 1'b0; reg_wr = 1'b0;
    rd(12'h000, status_exp(), "R10 count after push plus ack");
    rd(12'h004, win_exp(1), "R10 window word 1");
    rd(12'h008, win_exp(2), "R10 window word 2");

    // R5 clamp
    ack(100);
    rd(12'h000, status_exp(), "R5 clamped ack empties");
    rd(12'h004, 32'h0, "R9 empty window reads zero");

    // R7 trigger level 0 -> 4 bytes
    wr(12'h804, 32'h0000_0000); lvl_m = 0;
    for (int i = 0; i < 3; i++) push(8'hA0 + 8'(i));
    check("R7 irq_data below threshold", 32'(irq_data), 32'h0);
    push(8'hA3);
    check("R7 irq_data at threshold", 32'(irq_data), 32'h1);
    rd(12'h000, status_exp(), "R7 status mirrors request");
    ack(4);
    check("R7 irq_data after ack", 32'(irq_data), 32'h0);

    // R8 idle timeout: T=3, D=2 -> 24 cycles
    wr(12'h808, 32'd3);
    wr(12'h80C, 32'd2);
    push(8'h55);
    repeat (20) @(negedge clk);
    check("R8 no timeout before limit", 32'(irq_tmo), 32'h0);
    repeat (5) @(negedge clk);
    check("R8 timeout after limit", 32'(irq_tmo), 32'h1);
    ack(1);
    check("R8 timeout cleared by ack", 32'(irq_tmo), 32'h0);
    wr(12'h808, 32'd0);

    // R3/R6 fill completely at level 7
    wr(12'h804, 32'h0070_0000); lvl_m = 7;
    for (int i = 0; i < 1024; i++) begin
      push(8'(i) ^ 8'h5A);
      if (i == 699) rd(12'h000, status_exp(), "R3 split count at 700");
    end
    rd(12'h000, status_exp(), "R3 status when full");
    check("R7 irq_data at 512 level", 32'(irq_data), 32'h1);
    rd(12'h3FC, win_exp(255), "R2 last window word");
    push(8'hFF);
    rd(12'h000, status_exp(), "R6 overrun flag set");
    rd(12'h004, win_exp(1), "R6 oldest byte not overwritten");
    wr(12'h000, 32'h1); ovr_m = 1'b0;
    rd(12'h000, status_exp(), "R6 overrun cleared");
    ack(4);
    rd(12'h3FC, win_exp(255), "R4 window moved after ack 4");
    ack(2000);
    rd(12'h000, status_exp(), "R5 clamp from nearly full");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule